// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus. It gives a host access to a bank of eighteen 8-bit configuration registers. It takes SCL and SDA samples that are already synchronised to the core clock. It pulls the data line low through an open-drain enable, and it does nothing else on the bus. Start, repeated start and stop are detected in the core clock domain. Bits are shifted on SCL edges.

The first byte after the slave address is a command code. When bit 7 of the command is set, the transfer reads or writes one register, and bits 6:0 give its offset. When bit 7 is clear, the transfer is a block transfer. A block transfer always begins at register 0 and carries a byte count. On a write the host sends the count. On a read the slave returns the count first, and then the register contents in rising offset order.

Each stored byte is also presented on a one-cycle write strobe with its offset and data, so that other blocks can react to it. The full register view, including the read-only fields, is available in parallel on `cfg_o`.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges only the address byte 0xD2 (write) or 0xD3 (read), which is 7-bit address 0x69. Any other address gets no acknowledge, and the rest of that transfer changes no register and produces no strobe.
- R2: A write with a command byte that has bit 7 set stores the next data byte into the register whose offset is given by command bits 6:0.
- R3: A read (address+W, command with bit 7 set, repeated start, address+R) returns the register at offset command[6:0], MSB first.
- R4: A write with command 0x00 treats the byte after the command as a count and does not store it. The data bytes that follow go to registers 0, 1, 2 and upward.
- R5: A block read (command 0x00, repeated start, address+R) first returns the count 18 (0x12). It then returns registers 0, 1, 2 and upward while the host acknowledges. After the host's NACK the slave releases SDA.
- R6: After reset the register view reads: reg1=0xFF, reg2=0x7F, reg3=0xEB, reg6=0x08, reg8=0x3E, reg15=0x03. Every other register reads 0x00 while the strap input is zero.
- R7: Register 5 bits 7:3 always show the live 5-bit `strap_i`. Register 6 bits 3:0 always read the fixed ID 4'h8. Writes to these bits are ignored. The other bits of those registers stay writable.
- R8: In a block write, bytes beyond register 17 are acknowledged but are neither stored nor strobed.
- R9: Every stored byte produces exactly one single-cycle `wr_stb_o` pulse, carrying its offset on `wr_addr_o` and the byte on `wr_data_o`.
- R10: A stop returns the slave to idle with SDA released. A new start can then begin a fresh transfer.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample |
| sda_oe_o | output | 1 | Open-drain pull-down enable for SDA (1 = drive low) |
| strap_i | input | 5 | Live strap value shown in register 5 bits 7:3 |
| wr_stb_o | output | 1 | One-cycle pulse per stored byte |
| wr_addr_o | output | 7 | Register offset of the stored byte |
| wr_data_o | output | 8 | Value written |
| cfg_o | output | 144 | Register view, register i at bits 8*i+7 : 8*i |

## Verification
Each kind of internal fault shows up at the ports within one byte time:
- A wrong bit count or phase flag moves the acknowledge slot. The host then sees a missing ACK, or a data bit with a wrong value, on the very next byte.
- A pointer that fails to reset or advance shows up on `wr_addr_o` or in the `cfg_o` byte that changes, within one byte of the fault. In a block read it shows up as a data byte out of sequence.
- Faults in the read-only masking appear directly on `cfg_o` in the same cycle.
- A strobe that is stretched or repeated changes the count of strobe cycles seen per transfer.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam int STRAP_W = 5;
  localparam logic [3:0] VENDOR_ID = 4'h8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_WCNT, ST_WDAT, ST_RD
  } st_e;

  function automatic logic [7:0] reg_default(int idx);
    case (idx)
      1:       return 8'hFF;
      2:       return 8'h7F;
      3:       return 8'hEB;
      8:       return 8'h3E;
      15:      return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  // bits supplied from outside the store
  function automatic logic [7:0] ro_mask(int idx);
    case (idx)
      5:       return 8'hF8;
      6:       return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] live_val(int idx, logic [STRAP_W-1:0] s);
    case (idx)
      5:       return {s, 3'b000};
      6:       return {4'h0, VENDOR_ID};
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_line_mon.sv
module smb_line_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h69,
  parameter int         NREG  = 18,
  parameter int         PW    = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic          wr_stb_o,
  output logic [PW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic [PW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i
);
  localparam logic [PW-1:0] NREG_P = PW'(NREG);
  localparam logic [7:0]    CNT_B  = 8'(NREG);

  st_e           state_q;
  logic [7:0]    sh_q, tx_q;
  logic [3:0]    bcnt_q;
  logic          ackph_q, oe_q, blk_q, cnt_done_q;
  logic [PW-1:0] ptr_q, ptr_inc;
  logic          stb_q;
  logic [PW-1:0] waddr_q;
  logic [7:0]    wdata_q;
  logic [7:0]    nxt;
  logic          nxt_is_cnt;

  always_comb begin
    nxt_is_cnt = blk_q & ~cnt_done_q;
    nxt        = nxt_is_cnt ? CNT_B : rd_data_i;
    ptr_inc    = (ptr_q == '1) ? ptr_q : ptr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sh_q       <= '0;
      tx_q       <= '0;
      bcnt_q     <= '0;
      ackph_q    <= 1'b0;
      oe_q       <= 1'b0;
      blk_q      <= 1'b0;
      cnt_done_q <= 1'b0;
      ptr_q      <= '0;
      stb_q      <= 1'b0;
      waddr_q    <= '0;
      wdata_q    <= '0;
    end else begin
      stb_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        bcnt_q  <= '0;
        ackph_q <= 1'b0;
        oe_q    <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        ackph_q <= 1'b0;
        oe_q    <= 1'b0;
      end else if (state_q != ST_IDLE) begin
        if (rise_i) begin
          if (state_q == ST_RD) begin
            if (ackph_q) begin
              if (sda_i) begin       // host NACK ends the read
                state_q <= ST_IDLE;
                oe_q    <= 1'b0;
              end
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end else if (!ackph_q) begin
            sh_q   <= {sh_q[6:0], sda_i};
            bcnt_q <= bcnt_q + 1'b1;
          end
        end else if (fall_i) begin
          if (state_q == ST_RD) begin
            if (ackph_q) begin
              tx_q    <= nxt;
              oe_q    <= ~nxt[7];
              bcnt_q  <= '0;
              ackph_q <= 1'b0;
              if (nxt_is_cnt) cnt_done_q <= 1'b1;
              else            ptr_q      <= ptr_inc;
            end else if (bcnt_q == 4'd8) begin
              oe_q    <= 1'b0;
              ackph_q <= 1'b1;
            end else begin
              oe_q <= ~tx_q[6];
              tx_q <= {tx_q[6:0], 1'b0};
            end
          end else if (ackph_q) begin
            oe_q    <= 1'b0;
            ackph_q <= 1'b0;
            bcnt_q  <= '0;
          end else if (bcnt_q == 4'd8) begin
            ackph_q <= 1'b1;
            oe_q    <= 1'b1;
            unique case (state_q)
              ST_ADDR: begin
                if (sh_q[7:1] == ADDR7) begin
                  state_q <= sh_q[0] ? ST_RD : ST_CMD;
                end else begin
                  state_q <= ST_IDLE;
                  ackph_q <= 1'b0;
                  oe_q    <= 1'b0;
                end
              end
              ST_CMD: begin
                blk_q      <= ~sh_q[7];
                ptr_q      <= sh_q[7] ? sh_q[PW-1:0] : '0;
                cnt_done_q <= 1'b0;
                state_q    <= sh_q[7] ? ST_WDAT : ST_WCNT;
              end
              ST_WCNT: state_q <= ST_WDAT;
              ST_WDAT: begin
                if (ptr_q < NREG_P) begin
                  stb_q   <= 1'b1;
                  waddr_q <= ptr_q;
                  wdata_q <= sh_q;
                end
                ptr_q <= ptr_inc;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_stb_o  = stb_q;
  assign wr_addr_o = waddr_q;
  assign wr_data_o = wdata_q;
  assign rd_addr_o = ptr_q;

  // R10
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !oe_q);
  // R9
  stb_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);
  // R8
  stb_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> (waddr_q < NREG_P));
endmodule

// File: rtl/smb_reg_file.sv
module smb_reg_file
  import smb_cfg_pkg::*;
#(
  parameter int NREG = 18,
  parameter int PW   = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [PW-1:0]      waddr_i,
  input  logic [7:0]         wdata_i,
  input  logic [PW-1:0]      raddr_i,
  output logic [7:0]         rdata_o,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [NREG*8-1:0]  cfg_o
);
  logic [7:0] view [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] RO  = ro_mask(g);
    localparam logic [7:0] DEF = reg_default(g);
    logic [7:0] q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= DEF;
      else if (we_i && (waddr_i == PW'(g)))       q <= (q & RO) | (wdata_i & ~RO);
    end

    assign view[g]          = (q & ~RO) | (live_val(g, strap_i) & RO);
    assign cfg_o[g*8 +: 8]  = view[g];

    // R7
    ro_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $stable(q & RO));
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (raddr_i == PW'(i)) rdata_o = view[i];
  end
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h69,
  parameter int         NREG  = 18,
  parameter int         PW    = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               wr_stb_o,
  output logic [PW-1:0]      wr_addr_o,
  output logic [7:0]         wr_data_o,
  output logic [NREG*8-1:0]  cfg_o
);
  logic          rise, fall, start, stop;
  logic [PW-1:0] rd_addr;
  logic [7:0]    rd_data;

  smb_line_mon u_mon (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .rise_o(rise), .fall_o(fall), .start_o(start), .stop_o(stop)
  );

  smb_proto_fsm #(.ADDR7(ADDR7), .NREG(NREG), .PW(PW)) u_fsm (
    .clk_i, .rst_ni,
    .start_i(start), .stop_i(stop), .rise_i(rise), .fall_i(fall), .sda_i,
    .sda_oe_o, .wr_stb_o, .wr_addr_o, .wr_data_o,
    .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  smb_reg_file #(.NREG(NREG), .PW(PW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(wr_stb_o), .waddr_i(wr_addr_o), .wdata_i(wr_data_o),
    .raddr_i(rd_addr), .rdata_o(rd_data), .strap_i, .cfg_o
  );

  // R11
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_o) || $fell(sda_oe_o)) |-> !scl_i);
endmodule

// File: tb/smb_cfg_slave_tb.sv
module smb_cfg_slave_tb;
  localparam int Q = 10;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         scl = 1;
  logic         m_sda = 1;
  logic [4:0]   strap = 5'b0;
  logic         sda_oe;
  logic         wr_stb;
  logic [6:0]   wr_addr;
  logic [7:0]   wr_data;
  logic [143:0] cfg;
  logic         sda_bus;

  int total = 0, bad = 0;
  int stb_cycles = 0;
  logic [6:0] last_addr;
  logic [7:0] last_data;
  int hi_changes = 0;
  logic prev_oe = 0;
  logic ack;
  int ack_cnt;

  always #2 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  smb_cfg_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .strap_i(strap), .wr_stb_o(wr_stb),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .cfg_o(cfg)
  );

  always @(posedge clk) begin
    if (wr_stb) begin
      stb_cycles <= stb_cycles + 1;
      last_addr  <= wr_addr;
      last_data  <= wr_data;
    end
    if (scl && (sda_oe !== prev_oe)) hi_changes <= hi_changes + 1;
    prev_oe <= sda_oe;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_of(int i);
    return cfg[i*8 +: 8];
  endfunction

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1; scl = 1; w(Q); m_sda = 0; w(Q); scl = 0; w(Q);
  endtask

  task automatic bus_rstart;
    m_sda = 1; w(Q); scl = 1; w(Q); m_sda = 0; w(Q); scl = 0; w(Q);
  endtask

  task automatic bus_stop;
    m_sda = 0; w(Q); scl = 1; w(Q); m_sda = 1; w(Q);
  endtask

  task automatic wb(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; w(Q); scl = 1; w(2*Q); scl = 0; w(Q);
    end
    m_sda = 1; w(Q); scl = 1; w(Q); ack = ~sda_bus; w(Q); scl = 0; w(Q);
    if (ack) ack_cnt++;
  endtask

  task automatic rb(output logic [7:0] b, input logic give_ack);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); scl = 1; w(Q); b[i] = sda_bus; w(Q); scl = 0; w(Q);
    end
    m_sda = ~give_ack; w(Q); scl = 1; w(2*Q); scl = 0; w(Q); m_sda = 1;
  endtask

  task automatic read_reg(int off, output logic [7:0] v);
    bus_start; wb(8'hD2); wb(8'h80 | 8'(off)); bus_rstart; wb(8'hD3);
    rb(v, 1'b0); bus_stop;
  endtask

  task automatic t_reset;
    chk("R6 sda released", 32'(sda_oe), 0);
    chk("R6 reg0", reg_of(0), 8'h00);
    chk("R6 reg1", reg_of(1), 8'hFF);
    chk("R6 reg2", reg_of(2), 8'h7F);
    chk("R6 reg3", reg_of(3), 8'hEB);
    chk("R6 reg6", reg_of(6), 8'h08);
    chk("R6 reg8", reg_of(8), 8'h3E);
    chk("R6 reg15", reg_of(15), 8'h03);
    chk("R6 reg5", reg_of(5), 8'h00);
  endtask

  task automatic t_byte_write;
    int s0 = stb_cycles;
    ack_cnt = 0;
    bus_start; wb(8'hD2); chk("R1 addr ack", 32'(ack), 1);
    wb(8'h8A); wb(8'hA5); bus_stop;
    chk("R2 acks", ack_cnt, 3);
    chk("R2 reg10", reg_of(10), 8'hA5);
    chk("R9 one strobe cycle", stb_cycles - s0, 1);
    chk("R9 strobe addr", last_addr, 10);
    chk("R9 strobe data", last_data, 8'hA5);
  endtask

  task automatic t_byte_read;
    logic [7:0] v;
    read_reg(10, v); chk("R3 read reg10", v, 8'hA5);
    read_reg(1, v);  chk("R3 read reg1", v, 8'hFF);
    read_reg(8, v);  chk("R3 read reg8", v, 8'h3E);
  endtask

  task automatic t_bad_addr;
    int s0 = stb_cycles;
    ack_cnt = 0;
    bus_start; wb(8'hA4); wb(8'h8A); wb(8'h00); bus_stop;
    chk("R1 no ack", ack_cnt, 0);
    chk("R1 reg10 kept", reg_of(10), 8'hA5);
    chk("R1 no strobe", stb_cycles - s0, 0);
  endtask

  task automatic t_block_write;
    int s0 = stb_cycles;
    ack_cnt = 0;
    bus_start; wb(8'hD2); wb(8'h00); wb(8'h03);
    wb(8'h11); wb(8'h22); wb(8'h33); bus_stop;
    chk("R4 acks", ack_cnt, 6);
    chk("R4 reg0", reg_of(0), 8'h11);
    chk("R4 reg1", reg_of(1), 8'h22);
    chk("R4 reg2", reg_of(2), 8'h33);
    chk("R4 reg3 untouched", reg_of(3), 8'hEB);
    chk("R9 three strobes", stb_cycles - s0, 3);
  endtask

  task automatic t_block_read;
    logic [7:0] c, d0, d1, d2;
    bus_start; wb(8'hD2); wb(8'h00); bus_rstart; wb(8'hD3);
    rb(c, 1'b1); rb(d0, 1'b1); rb(d1, 1'b1); rb(d2, 1'b0);
    chk("R5 released after nack", 32'(sda_oe), 0);
    bus_stop;
    chk("R5 count", c, 8'h12);
    chk("R5 data0", d0, 8'h11);
    chk("R5 data1", d1, 8'h22);
    chk("R5 data2", d2, 8'h33);
    chk("R10 idle released", 32'(sda_oe), 0);
  endtask

  task automatic t_read_only;
    logic [7:0] v;
    strap = 5'b10110;
    bus_start; wb(8'hD2); wb(8'h85); wb(8'h00); bus_stop;
    read_reg(5, v); chk("R7 reg5 strap", v, 8'hB0);
    strap = 5'b01001; w(2);
    chk("R7 reg5 live", reg_of(5), 8'h48);
    bus_start; wb(8'hD2); wb(8'h86); wb(8'hF7); bus_stop;
    read_reg(6, v); chk("R7 reg6 id kept", v, 8'hF8);
  endtask

  task automatic t_abort;
    logic [7:0] v;
    bus_start; wb(8'hD2); bus_stop;
    chk("R10 stop releases", 32'(sda_oe), 0);
    read_reg(2, v); chk("R10 fresh transfer", v, 8'h33);
  endtask

  task automatic t_overrun;
    int s0 = stb_cycles;
    ack_cnt = 0;
    bus_start; wb(8'hD2); wb(8'h00); wb(8'd20);
    for (int i = 0; i < 20; i++) wb(8'h40 + 8'(i));
    bus_stop;
    chk("R8 all acked", ack_cnt, 23);
    chk("R8 strobes capped", stb_cycles - s0, 18);
    chk("R8 last addr", last_addr, 17);
    chk("R8 last data", last_data, 8'h51);
    chk("R8 reg0", reg_of(0), 8'h40);
    chk("R8 reg17", reg_of(17), 8'h51);
    chk("R7 reg5 mixed", reg_of(5), 8'h4D);
  endtask

  initial begin
    w(5); rst_n = 1; w(5);
    t_reset;
    t_byte_write;
    t_byte_read;
    t_bad_addr;
    t_block_write;
    t_block_read;
    t_read_only;
    t_abort;
    t_overrun;
    chk("R11 no change while scl high", hi_changes, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule